// File: doc/BRIEF.md
# Local Interrupt Timer

The block is a down-counting interrupt timer for a processor's local interrupt controller. Software writes two registers: a 32-bit control word, which names the vector, delivery mode and trigger kind of the interrupt to raise, together with a mask bit and a periodic-mode bit, and an initial-count register. Writing a nonzero initial count loads the counter and starts it. The counter then steps down by one on every cycle in which the tick enable is high.

When the counter expires, the block sends a one-cycle request to the interrupt acceptor. The request carries the vector, delivery mode and trigger bit from the control word, and is sent only if the mask bit is clear. In periodic mode the counter reloads from the initial count and keeps running. The reload happens even while the request is masked. In one-shot mode the counter stops at zero and stays there until a new initial count is written.

Top module: `local_irq_timer`

## Requirements
- R1: Control-word layout: vector in bits 7:0, delivery mode in bits 10:8, trigger kind in bit 15 (1 = level), mask in bit 16 (1 = masked), periodic mode in bit 17 (1 = periodic). Bits 12, 13, 14 and 31:18 are ignored. A write with `wr_sel_i` = 1 targets the control word; a write with `wr_sel_i` = 0 targets the initial count.
- R2: Writing a nonzero initial count N loads the counter and starts it. The counter drops by one at each clock edge where `tick_i` is high, and it expires on the Nth such tick.
- R3: A request carries the vector, mode and trigger bit that the control word held at the edge of expiry.
- R4: An expiry while the mask bit is set raises no request.
- R5: In periodic mode an expiry reloads the counter from the initial count, whether or not the word is masked, so a new expiry follows every N ticks.
- R6: In one-shot mode an expiry stops the timer. No further request follows until the initial count is written again.
- R7: Writing an initial count of zero stops the timer at once and raises no request.
- R8: `req_valid_o` is high for exactly the one cycle after the edge of each expiry. Consecutive requests occur only when expiries fall on consecutive edges.
- R9: After reset the timer is stopped, no request is raised, and the control word reads as masked, one-shot, with every other field zero.
- R10: A control-word write does not disturb the running count. Cycles with `tick_i` low leave the count unchanged.
- R11: Writing an initial count while the timer is running restarts the countdown from the new value. A count write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 initial count, 1 control word |
| wr_data_i | input | DATA_W | Write data |
| tick_i | input | 1 | Count enable, one decrement per high cycle |
| req_valid_o | output | 1 | One-cycle interrupt request |
| req_vector_o | output | 8 | Requested vector |
| req_mode_o | output | 3 | Requested delivery mode |
| req_level_o | output | 1 | Requested trigger kind, 1 = level |

## Verification
The assertions check the following on every cycle:
- the single-step decrement;
- the reload to the initial count on a periodic expiry;
- the stop to zero on a one-shot expiry;
- the stop after a zero count write;
- that every request follows a tick and an unmasked control word, with the fields that word held.

Only the bench scenarios can show the end-to-end periods and the ignored control bits. These scenarios include a masked periodic run that, once unmasked, keeps its original phase, and a restart in the middle of a countdown. They also cover a control-word write during a countdown that changes the vector without shifting the expiry, and back-to-back requests with a count of one.

// File: rtl/lit_pkg.sv
package lit_pkg;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned MODE_W   = 3;
  localparam int unsigned VEC_LSB  = 0;
  localparam int unsigned MODE_LSB = 8;
  localparam int unsigned LVL_BIT  = 15;
  localparam int unsigned MASK_BIT = 16;
  localparam int unsigned PER_BIT  = 17;

  typedef struct packed {
    logic              periodic;
    logic              masked;
    logic              level;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vector;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{periodic: 1'b0, masked: 1'b1, level: 1'b0,
                                 mode: '0, vector: '0};

  function automatic ctrl_t decode_ctrl(input logic [31:0] w);
    ctrl_t c;
    c.vector   = w[VEC_LSB +: VEC_W];
    c.mode     = w[MODE_LSB +: MODE_W];
    c.level    = w[LVL_BIT];
    c.masked   = w[MASK_BIT];
    c.periodic = w[PER_BIT];
    return c;
  endfunction
endpackage

// File: rtl/lit_ctrl_reg.sv
module lit_ctrl_reg
  import lit_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] data_i,
  output ctrl_t             ctrl_o
);
  logic [31:0] word;
  ctrl_t       ctrl_q;

  // zero-extend or truncate so the field positions stay fixed
  assign word = 32'(data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= CTRL_RST;
    else if (we_i) ctrl_q <= decode_ctrl(word);
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/lit_counter.sv
module lit_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] init_o,
  output logic             active_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, init_q;
  logic             active_q;

  // count write wins over a tick in the same cycle
  assign expire_o = !load_i && tick_i && active_q && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      init_q   <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      cnt_q    <= load_val_i;
      init_q   <= load_val_i;
      active_q <= |load_val_i;
    end else if (expire_o) begin
      if (periodic_i) begin
        cnt_q <= init_q;
      end else begin
        cnt_q    <= '0;
        active_q <= 1'b0;
      end
    end else if (tick_i && active_q) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o    = cnt_q;
  assign init_o   = init_q;
  assign active_o = active_q;
endmodule

// File: rtl/lit_req_gen.sv
module lit_req_gen
  import lit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              expire_i,
  input  ctrl_t             ctrl_i,
  output logic              valid_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              level_o
);
  logic fire;

  assign fire = expire_i && !ctrl_i.masked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      vector_o <= '0;
      mode_o   <= '0;
      level_o  <= 1'b0;
    end else begin
      valid_o <= fire;
      if (fire) begin
        vector_o <= ctrl_i.vector;
        mode_o   <= ctrl_i.mode;
        level_o  <= ctrl_i.level;
      end
    end
  end
endmodule

// File: rtl/local_irq_timer.sv
module local_irq_timer
  import lit_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  output logic              req_valid_o,
  output logic [7:0]        req_vector_o,
  output logic [2:0]        req_mode_o,
  output logic              req_level_o
);
  ctrl_t            ctrl;
  logic             cnt_we, ctrl_we, expire, active;
  logic [CNT_W-1:0] cnt, init_cnt, load_val;

  assign cnt_we   = wr_en_i && !wr_sel_i;
  assign ctrl_we  = wr_en_i && wr_sel_i;
  assign load_val = CNT_W'(wr_data_i);

  lit_ctrl_reg #(.DATA_W(DATA_W)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctrl_we),
    .data_i (wr_data_i),
    .ctrl_o (ctrl)
  );

  lit_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_we),
    .load_val_i (load_val),
    .tick_i     (tick_i),
    .periodic_i (ctrl.periodic),
    .cnt_o      (cnt),
    .init_o     (init_cnt),
    .active_o   (active),
    .expire_o   (expire)
  );

  lit_req_gen i_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .ctrl_i   (ctrl),
    .valid_o  (req_valid_o),
    .vector_o (req_vector_o),
    .mode_o   (req_mode_o),
    .level_o  (req_level_o)
  );
endmodule

// File: rtl/lit_checker.sv
module lit_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              tick_i,
  input logic              req_valid_i,
  input logic [7:0]        req_vector_i,
  input logic [2:0]        req_mode_i,
  input logic              req_level_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  init_i,
  input logic              active_i,
  input logic [7:0]        c_vec_i,
  input logic [2:0]        c_mode_i,
  input logic              c_level_i,
  input logic              c_mask_i,
  input logic              c_per_i
);
  logic cw, at_end;
  assign cw     = wr_en_i && !wr_sel_i;
  assign at_end = !cw && tick_i && active_i && (cnt_i == CNT_W'(1));

  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cw && tick_i && active_i && cnt_i > CNT_W'(1)) |=> cnt_i == $past(cnt_i) - CNT_W'(1)); // R2
  AST_REQ_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (req_vector_i == $past(c_vec_i) && req_mode_i == $past(c_mode_i)
                     && req_level_i == $past(c_level_i))); // R3
  AST_MASK_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> !$past(c_mask_i)); // R4
  AST_PERIODIC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_end && c_per_i) |=> (cnt_i == $past(init_i) && active_i)); // R5
  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_end && !c_per_i) |=> (!active_i && cnt_i == '0)); // R6
  AST_ZERO_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw && wr_data_i[CNT_W-1:0] == '0) |=> (!active_i && !req_valid_i)); // R7
  AST_REQ_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> ($past(tick_i) && !$past(cw))); // R8
endmodule

bind local_irq_timer lit_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_lit_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .wr_data_i    (wr_data_i),
  .tick_i       (tick_i),
  .req_valid_i  (req_valid_o),
  .req_vector_i (req_vector_o),
  .req_mode_i   (req_mode_o),
  .req_level_i  (req_level_o),
  .cnt_i        (cnt),
  .init_i       (init_cnt),
  .active_i     (active),
  .c_vec_i      (ctrl.vector),
  .c_mode_i     (ctrl.mode),
  .c_level_i    (ctrl.level),
  .c_mask_i     (ctrl.masked),
  .c_per_i      (ctrl.periodic)
);

// File: tb/test_local_irq_timer.sv
`timescale 1ns/1ps
module test_local_irq_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_sel_i = 1'b0, tick_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        req_valid_o, req_level_o;
  logic [7:0]  req_vector_o;
  logic [2:0]  req_mode_o;

  int errors = 0, checks = 0, cycles = 0, dut_reqs = 0;
  logic [7:0] last_vec;
  string cur_tag = "R9";

  // reference model state
  longint m_cnt, m_init;
  bit m_act, m_req, m_mask, m_per, m_lvl, m_rlvl;
  bit [7:0] m_vec, m_rvec;
  bit [2:0] m_mode, m_rmode;

  always #5 clk_i = ~clk_i;

  local_irq_timer i_local_irq_timer (.*);

  task automatic check(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_cnt = 0; m_init = 0; m_act = 0; m_req = 0;
      m_mask = 1; m_per = 0; m_lvl = 0; m_vec = 0; m_mode = 0;
    end else begin
      m_req = 0;
      if (wr_en_i && !wr_sel_i) begin
        m_init = wr_data_i; m_cnt = wr_data_i; m_act = (wr_data_i != 0);
      end else if (tick_i && m_act) begin
        if (m_cnt == 1) begin
          if (!m_mask) begin
            m_req = 1; m_rvec = m_vec; m_rmode = m_mode; m_rlvl = m_lvl;
          end
          if (m_per) m_cnt = m_init;
          else begin m_cnt = 0; m_act = 0; end
        end else m_cnt = m_cnt - 1;
      end
      if (wr_en_i && wr_sel_i) begin
        m_vec = wr_data_i[7:0]; m_mode = wr_data_i[10:8]; m_lvl = wr_data_i[15];
        m_mask = wr_data_i[16]; m_per = wr_data_i[17];
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      check({cur_tag, " req_valid"}, req_valid_o == m_req, req_valid_o, m_req);
      if (m_req && req_valid_o) begin
        check("R3 fields", {req_vector_o, req_mode_o, req_level_o} == {m_rvec, m_rmode, m_rlvl},
              {req_vector_o, req_mode_o, req_level_o}, {m_rvec, m_rmode, m_rlvl});
      end
      if (req_valid_o) begin
        dut_reqs++;
        last_vec = req_vector_o;
      end
    end
  end

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d; tick_i = 1'b0;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // n cycles; tick every cycle, or every other one when sparse
  task automatic run(input int n, input bit sparse, output int got);
    int base;
    base = dut_reqs;
    for (int i = 0; i < n; i++) begin
      tick_i = sparse ? i[0] : 1'b1;
      @(negedge clk_i);
    end
    tick_i = 1'b0;
    #1;
    got = dut_reqs - base;
  endtask

  initial begin
    int got;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R9 reset no request", req_valid_o == 1'b0, req_valid_o, 0);
    // R9: reset word is masked one-shot
    wr(0, 32'd3);
    run(10, 0, got);
    check("R9 reset masked", got == 0, got, 0);

    // R1/R2/R3: ignored bits set, vector 0x41, mode 5, level, unmasked one-shot
    cur_tag = "R1";
    wr(1, 32'hFFFC_F541);
    wr(0, 32'd5);
    run(4, 0, got);
    check("R2 not before N ticks", got == 0, got, 0);
    run(1, 0, got);
    check("R2 expiry on Nth tick", got == 1, got, 1);
    check("R1 vector field", last_vec == 8'h41, last_vec, 8'h41);
    run(8, 0, got);
    check("R6 one-shot stays stopped", got == 0, got, 0);

    // R5 periodic, count 4, 20 ticks
    cur_tag = "R5";
    wr(1, 32'h0002_0422);
    wr(0, 32'd4);
    run(20, 0, got);
    check("R5 periodic count", got == 5, got, 5);

    // R4/R5 masked periodic keeps reloading; unmask keeps phase
    cur_tag = "R4";
    wr(1, 32'h0003_0033);
    wr(0, 32'd3);
    run(7, 0, got);
    check("R4 masked silent", got == 0, got, 0);
    wr(1, 32'h0002_0033);
    run(5, 0, got);
    check("R5 reload under mask", got == 2, got, 2);

    // R7 zero write stops
    cur_tag = "R7";
    wr(1, 32'h0000_0010);
    wr(0, 32'd5);
    run(2, 0, got);
    wr(0, 32'd0);
    run(10, 0, got);
    check("R7 zero stops", got == 0, got, 0);

    // R11 restart mid-count
    cur_tag = "R11";
    wr(0, 32'd6);
    run(4, 0, got);
    wr(0, 32'd6);
    run(5, 0, got);
    check("R11 restart delays", got == 0, got, 0);
    run(1, 0, got);
    check("R11 restart expiry", got == 1, got, 1);

    // R10 sparse ticks and word write mid-count
    cur_tag = "R10";
    wr(0, 32'd4);
    run(7, 1, got);
    check("R10 gaps hold count", got == 0, got, 0);
    run(2, 1, got);
    check("R10 expiry after 4 ticks", got == 1, got, 1);
    wr(0, 32'd5);
    run(2, 0, got);
    wr(1, 32'h0000_007E);
    run(2, 0, got);
    check("R10 word write no shift early", got == 0, got, 0);
    run(1, 0, got);
    check("R10 word write no shift", got == 1, got, 1);
    check("R3 new vector used", last_vec == 8'h7E, last_vec, 8'h7E);

    // R8 count of one periodic: back-to-back pulses, then quiet
    cur_tag = "R8";
    wr(1, 32'h0002_0001);
    wr(0, 32'd1);
    run(5, 0, got);
    check("R8 back-to-back", got == 5, got, 5);
    @(negedge clk_i);
    check("R8 pulse ends", req_valid_o == 1'b0, req_valid_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule